// File: doc/BRIEF.md
# Byte-Order and Sign-Extending Move Unit

This unit carries out the two unary reshaping operations of a 64-bit packet-filter instruction set. One is byte-order conversion, which acts on the destination register alone. The other is the register move, which comes in a plain form and in a sign-extending form. Each accepted request produces a registered result one clock later.

The host byte order is little-endian. Converting to little endian therefore only cuts the value down to the selected width and zero-fills the rest. Converting to big endian reverses the bytes within that width. In the 64-bit class the order bit is reserved, and the bytes are always swapped. A move carries its sign-extension width in the offset field; an offset of zero selects the plain move.

An encoding the unit does not support sets the illegal flag and returns the destination value unchanged. The unit is meant to sit in an execute stage beside the main arithmetic unit.

Top module: `reshape_unit`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one cycle. `result` and `illegal` change only in the cycle after an accepted request and otherwise hold. After reset all three outputs are 0.
- R2: Byte-order operation (`op_code`=4'hD), 32-bit class (`wide`=0), `order_sel`=0. The result is the low W bits of `dst_val`, zero-extended, where W = `imm` and W must be 16, 32 or 64.
- R3: Byte-order operation, 32-bit class, `order_sel`=1. The result is the low W bits of `dst_val` with their bytes reversed, zero-extended to 64 bits.
- R4: Byte-order operation, 64-bit class, `order_sel`=0. The result is the low W bits of `dst_val` byte-reversed and zero-extended, the same result as R3.
- R5: Byte-order operation, 64-bit class, `order_sel`=1. This is illegal.
- R6: A byte-order operation whose `imm` is not exactly 16, 32 or 64 is illegal.
- R7: Move (`op_code`=4'hB) with `offset`=0. The 64-bit class copies `src_val`. The 32-bit class returns the low 32 bits of `src_val` with the upper 32 bits zero.
- R8: Move, 32-bit class, `offset` 8 or 16. The low 8 or 16 bits of `src_val` are sign-extended to 32 bits, and the upper 32 bits are zero.
- R9: Move, 64-bit class, `offset` 8, 16 or 32. The low 8, 16 or 32 bits of `src_val` are sign-extended to 64 bits.
- R10: A move with any other `offset` is illegal. This includes `offset` 32 in the 32-bit class.
- R11: Every `op_code` other than 4'hB and 4'hD is illegal. Whenever `illegal` is 1, `result` equals the `dst_val` of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation code (upper nibble of the code field) |
| order_sel | input | 1 | Byte-order select: 0 little endian, 1 big endian |
| wide | input | 1 | Instruction class: 1 = 64-bit, 0 = 32-bit |
| offset | input | 16 | Offset field; sign-extension width for moves |
| imm | input | 32 | Immediate; swap width for byte-order operations |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | New destination value |
| illegal | output | 1 | Unsupported encoding |

## Verification
The operands have bytes that are all distinct and carry dirty upper bits, so each error shows up in the result:
- A swap that reverses the full 64 bits instead of the selected width moves bytes into the wrong lanes.
- A truncation that leaks upper bits leaves stale high bytes in the result.

The sign-extending moves are driven with both negative and positive values in each size. A 32-bit class that failed to clear the upper word would show ones above bit 31.

Offset 32 in the 32-bit class, the reserved order bit in the 64-bit class, and near-miss widths such as 8 and 128 must all return `dst_val` with the flag set. A decoder that accepted any of them would emit a computed value instead.

// File: rtl/reshape_pkg.sv
package reshape_pkg;

    localparam int XLEN   = 64;
    localparam int NBYTES = XLEN / 8;
    localparam int NSIZE  = 3;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [3:0] {
        OPC_MOVE  = 4'hB,
        OPC_ORDER = 4'hD
    } opc_e;

    typedef enum logic [1:0] {
        K_BAD   = 2'd0,
        K_ORDER = 2'd1,
        K_MOVE  = 2'd2,
        K_SEXT  = 2'd3
    } kind_e;

    typedef struct packed {
        logic  vld;
        logic  bad;
        word_t val;
    } state_t;

    // keep bits [n-1:0], clear the rest
    function automatic word_t keep_low(input word_t v, input int n);
        word_t r;
        r = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (i < n) r[i] = v[i];
        end
        return r;
    endfunction

    // reverse the lowest nb bytes, clear the rest
    function automatic word_t rev_bytes(input word_t v, input int nb);
        word_t r;
        r = '0;
        for (int b = 0; b < NBYTES; b++) begin
            for (int j = 0; j < NBYTES; j++) begin
                if (b < nb && j == nb - 1 - b) r[8*b +: 8] = v[8*j +: 8];
            end
        end
        return r;
    endfunction

    // sign-extend bit n-1 across the word
    function automatic word_t sext_from(input word_t v, input int n);
        word_t r;
        logic  s;
        s = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            if (i == n - 1) s = v[i];
        end
        for (int i = 0; i < XLEN; i++) begin
            r[i] = (i < n) ? v[i] : s;
        end
        return r;
    endfunction

endpackage

// File: rtl/reshape_decode.sv
module reshape_decode
    import reshape_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic [3:0]       op_code,
    input  logic             order_sel,
    input  logic             wide,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    output kind_e            kind,
    output logic [1:0]       wsel,
    output logic             rev,
    output logic [1:0]       ssel
);

    logic w_ok;

    // swap width: 16 -> 0, 32 -> 1, 64 -> 2
    always_comb begin
        w_ok = 1'b1;
        wsel = 2'd0;
        case (imm)
            IMM_W'(16): wsel = 2'd0;
            IMM_W'(32): wsel = 2'd1;
            IMM_W'(64): wsel = 2'd2;
            default:    w_ok = 1'b0;
        endcase
    end

    always_comb begin
        kind = K_BAD;
        rev  = 1'b0;
        ssel = 2'd0;
        if (op_code == OPC_ORDER) begin
            if (wide) begin
                rev = 1'b1;
                if (!order_sel && w_ok) kind = K_ORDER;
            end else begin
                rev = order_sel;
                if (w_ok) kind = K_ORDER;
            end
        end else if (op_code == OPC_MOVE) begin
            case (offset)
                OFF_W'(0):  kind = K_MOVE;
                OFF_W'(8):  begin kind = K_SEXT; ssel = 2'd0; end
                OFF_W'(16): begin kind = K_SEXT; ssel = 2'd1; end
                OFF_W'(32): begin
                    ssel = 2'd2;
                    if (wide) kind = K_SEXT;
                end
                default:    kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/reshape_swap.sv
module reshape_swap
    import reshape_pkg::*;
(
    input  word_t      din,
    input  logic [1:0] wsel,
    input  logic       rev,
    output word_t      dout
);

    word_t trunc_v [NSIZE];
    word_t swap_v  [NSIZE];

    for (genvar k = 0; k < NSIZE; k++) begin : g_width
        localparam int W = 16 << k;
        assign trunc_v[k] = keep_low(din, W);
        assign swap_v[k]  = rev_bytes(din, W / 8);
    end

    always_comb begin
        case (wsel)
            2'd0:    dout = rev ? swap_v[0] : trunc_v[0];
            2'd1:    dout = rev ? swap_v[1] : trunc_v[1];
            2'd2:    dout = rev ? swap_v[2] : trunc_v[2];
            default: dout = '0;
        endcase
    end

endmodule

// File: rtl/reshape_sext.sv
module reshape_sext
    import reshape_pkg::*;
(
    input  word_t      din,
    input  logic [1:0] ssel,
    input  logic       wide,
    output word_t      dout
);

    localparam int HALF = XLEN / 2;

    word_t ext_v [NSIZE];

    for (genvar k = 0; k < NSIZE; k++) begin : g_size
        localparam int S = 8 << k;
        assign ext_v[k] = sext_from(din, S);
    end

    word_t pick;

    always_comb begin
        case (ssel)
            2'd0:    pick = ext_v[0];
            2'd1:    pick = ext_v[1];
            2'd2:    pick = ext_v[2];
            default: pick = '0;
        endcase
        dout = wide ? pick : {{HALF{1'b0}}, pick[HALF-1:0]};
    end

endmodule

// File: rtl/reshape_unit.sv
module reshape_unit
    import reshape_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op_code,
    input  logic             order_sel,
    input  logic             wide,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    output logic             out_valid,
    output logic             illegal,
    output logic [XLEN-1:0]  result
);

    localparam int HALF = XLEN / 2;

    kind_e      kind;
    logic [1:0] wsel, ssel;
    logic       rev;
    word_t      swap_out, sext_out, move_out;
    state_t     st_d, st_q;

    reshape_decode #(.OFF_W(OFF_W), .IMM_W(IMM_W)) u_dec (
        .op_code   (op_code),
        .order_sel (order_sel),
        .wide      (wide),
        .offset    (offset),
        .imm       (imm),
        .kind      (kind),
        .wsel      (wsel),
        .rev       (rev),
        .ssel      (ssel)
    );

    reshape_swap u_swap (
        .din  (dst_val),
        .wsel (wsel),
        .rev  (rev),
        .dout (swap_out)
    );

    reshape_sext u_sext (
        .din  (src_val),
        .ssel (ssel),
        .wide (wide),
        .dout (sext_out)
    );

    assign move_out = wide ? src_val : {{HALF{1'b0}}, src_val[HALF-1:0]};

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.bad = 1'b0;
            case (kind)
                K_ORDER: st_d.val = swap_out;
                K_MOVE:  st_d.val = move_out;
                K_SEXT:  st_d.val = sext_out;
                default: begin
                    st_d.bad = 1'b1;
                    st_d.val = dst_val;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign illegal   = st_q.bad;
    assign result    = st_q.val;

    a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal)));

    a_r11_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code != 4'hB && op_code != 4'hD)
            |=> (illegal && result == $past(dst_val)));

    a_r5_reserved_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'hD && wide && order_sel) |=> illegal);

    a_r2_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'hD && imm == IMM_W'(16) && !(wide && order_sel))
            |=> (!illegal && result[XLEN-1:16] == '0));

    a_r8_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'hB && !wide && (offset == OFF_W'(8) || offset == OFF_W'(16)))
            |=> (!illegal && result[XLEN-1:HALF] == '0));

    a_r10_sext32_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'hB && !wide && offset == OFF_W'(32))
            |=> (illegal && result == $past(dst_val)));

endmodule

// File: tb/reshape_unit_bench.sv
module reshape_unit_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [63:0] val;
        logic        bad;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        order_sel = 1'b0;
    logic        wide = 1'b0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic        out_valid, illegal;
    logic [63:0] result;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reshape_unit u_reshape_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .order_sel(order_sel), .wide(wide), .offset(offset), .imm(imm),
        .dst_val(dst_val), .src_val(src_val), .out_valid(out_valid),
        .illegal(illegal), .result(result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent reference
    function automatic exp_t model(input logic [3:0] op, input logic ob, input logic w64,
                                   input logic [15:0] off, input logic [31:0] im,
                                   input logic [63:0] d, input logic [63:0] s);
        exp_t e;
        e.bad = 1'b0;
        e.val = 64'h0;
        if (op == 4'hD) begin
            if ((w64 && ob) || !(im == 16 || im == 32 || im == 64)) e.bad = 1'b1;
            else if (!w64 && !ob) begin
                if (im == 16)      e.val = {48'h0, d[15:0]};
                else if (im == 32) e.val = {32'h0, d[31:0]};
                else               e.val = d;
            end else begin
                if (im == 16)      e.val = {48'h0, {<<8{d[15:0]}}};
                else if (im == 32) e.val = {32'h0, {<<8{d[31:0]}}};
                else               e.val = {<<8{d}};
            end
        end else if (op == 4'hB) begin
            if (off == 0)                 e.val = w64 ? s : {32'h0, s[31:0]};
            else if (off == 8)            e.val = w64 ? {{56{s[7]}}, s[7:0]}   : {32'h0, {24{s[7]}}, s[7:0]};
            else if (off == 16)           e.val = w64 ? {{48{s[15]}}, s[15:0]} : {32'h0, {16{s[15]}}, s[15:0]};
            else if (off == 32 && w64)    e.val = {{32{s[31]}}, s[31:0]};
            else                          e.bad = 1'b1;
        end else e.bad = 1'b1;
        if (e.bad) e.val = d;
        return e;
    endfunction

    task automatic drive(input string tag, input logic [3:0] op, input logic ob, input logic w64,
                         input logic [15:0] off, input logic [31:0] im,
                         input logic [63:0] d, input logic [63:0] s);
        exp_t e;
        e = model(op, ob, w64, off, im, d, s);
        e.tag = tag;
        sb.push_back(e);
        in_valid = 1'b1; op_code = op; order_sel = ob; wide = w64;
        offset = off; imm = im; dst_val = d; src_val = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R1: actual=unexpected out_valid expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, result, e.val);
                check({e.tag, " flag"}, {63'h0, illegal}, {63'h0, e.bad});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    localparam logic [63:0] D = 64'h8877_6655_4433_2211;
    localparam logic [63:0] S_NEG = 64'hF0E1_D2C3_B4A5_9687;
    localparam logic [63:0] S_POS = 64'h0123_4567_7A6B_5C4D;

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'h0, out_valid}, 64'h0);
        check("R1 reset result", result, 64'h0);
        check("R1 reset flag", {63'h0, illegal}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        drive("R2 le16", 4'hD, 0, 0, 0, 16, D, S_NEG);
        drive("R2 le32", 4'hD, 0, 0, 0, 32, D, S_NEG);
        drive("R2 le64", 4'hD, 0, 0, 0, 64, D, S_NEG);
        drive("R3 be16", 4'hD, 1, 0, 0, 16, D, S_NEG);
        drive("R3 be32", 4'hD, 1, 0, 0, 32, D, S_NEG);
        drive("R3 be64", 4'hD, 1, 0, 0, 64, D, S_NEG);
        drive("R4 sw16", 4'hD, 0, 1, 0, 16, D, S_NEG);
        drive("R4 sw32", 4'hD, 0, 1, 0, 32, D, S_NEG);
        drive("R4 sw64", 4'hD, 0, 1, 0, 64, D, S_NEG);
        drive("R5 reserved", 4'hD, 1, 1, 0, 32, D, S_NEG);
        drive("R6 w0", 4'hD, 0, 0, 0, 0, D, S_NEG);
        drive("R6 w8", 4'hD, 1, 0, 0, 8, D, S_NEG);
        drive("R6 w128", 4'hD, 0, 1, 0, 128, D, S_NEG);
        drive("R7 mov64", 4'hB, 0, 1, 0, 0, D, S_NEG);
        drive("R7 mov32", 4'hB, 0, 0, 0, 0, D, S_NEG);
        drive("R8 s8 neg", 4'hB, 0, 0, 8, 0, D, S_NEG);
        drive("R8 s16 neg", 4'hB, 0, 0, 16, 0, D, S_NEG);
        drive("R8 s8 pos", 4'hB, 0, 0, 8, 0, D, S_POS);
        drive("R8 s16 pos", 4'hB, 0, 0, 16, 0, D, S_POS);
        drive("R9 s8", 4'hB, 0, 1, 8, 0, D, S_NEG);
        drive("R9 s16", 4'hB, 0, 1, 16, 0, D, S_NEG);
        drive("R9 s32 neg", 4'hB, 0, 1, 32, 0, D, S_NEG);
        drive("R9 s32 pos", 4'hB, 0, 1, 32, 0, D, S_POS);
        drive("R10 s32 narrow", 4'hB, 0, 0, 32, 0, D, S_NEG);
        drive("R10 off4", 4'hB, 0, 1, 4, 0, D, S_NEG);
        drive("R10 off64", 4'hB, 0, 1, 64, 0, D, S_NEG);
        drive("R11 op0", 4'h0, 0, 1, 0, 16, D, S_NEG);
        drive("R11 opA", 4'hA, 0, 0, 0, 0, 64'h1234, S_NEG);

        @(negedge clk);
        held = result;
        drive("R1 last", 4'hB, 0, 1, 0, 0, D, 64'h5555_AAAA_0F0F_F0F0);
        @(negedge clk);
        held = result;
        in_valid = 1'b0; op_code = 4'hD; imm = 16; dst_val = 64'hFFFF;
        repeat (3) @(negedge clk);
        check("R1 idle valid", {63'h0, out_valid}, 64'h0);
        check("R1 idle hold", result, held);
        check("R1 queue drained", 64'(sb.size()), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule